// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. It divides the system clock down to a slower converter clock. It accepts conversion requests from three sources: a software start strobe, a selected hardware trigger, or an automatic restart in free-running mode. It then runs a binary search, most significant bit first, by driving a code to the DAC and reading back a single comparator bit. When the search ends, it delivers the result together with a one-cycle strobe, sets a sticky completion flag, and raises an interrupt request if that interrupt is enabled.

The channel and reference selection is double-buffered. Software writes land in a holding register. The active selection, which drives the analog multiplexer, is frozen while a conversion is running, so a write made during a conversion only takes effect for the next one.

The result interface is a plain strobe with no back-pressure. `res_valid` is high for exactly one clock. `res_data` holds its value until the next completion. A consumer that misses the strobe can still read the sticky `flag`.

Top module: `sar_conv_seq`

## Requirements
- R1: The converter clock ticks once every N system clocks. N is 2, 2, 4, 8, 16, 32, 64 or 128 for `ps_sel` values 0 to 7. The first tick falls on the N-th clock edge at which `en` is sampled high. A start request sampled at edge s begins the conversion at the first tick strictly after s.
- R2: `busy` goes high on the clock after a start request is sampled. It stays high for the whole conversion and drops together with the result strobe when not free-running. A start request (`start_wr` or a trigger) is ignored while `busy` is high or `en` is low.
- R3: A normal conversion ends on the 13th converter tick, counting the starting tick as the first. `res_valid` is therefore high in the cycle after the edge that lies 12·N system clocks after the starting tick.
- R4: The first conversion after `en` rises lasts 25 ticks, so its end edge is 24·N system clocks after its starting tick.
- R5: `cmp`=1 means the input is at or above `dac_code`. The trials run MSB first. Each trial bit is kept when `cmp` is 1 and cleared when it is 0. For every input code 0 to 1023, `res_data` equals the input code.
- R6: Every completion sets `flag`, whatever the value of `irq_en`. `irq` equals `flag` AND `irq_en`. A `flag_clr` pulse clears `flag`. If `flag_clr` falls in the same cycle as `res_valid`, `flag` ends up set.
- R7: With `auto_en`=1 and `trig_sel`=0 (free-running), a new conversion starts at the next tick after each completion. The results are spaced 13·N clocks apart, `busy` stays high, and `flag` has no effect. The very first conversion still needs `start_wr`.
- R8: With `auto_en`=1 and `trig_sel`=2 or 3, a rising edge on `ext_trig[0]` or `ext_trig[1]` respectively starts a conversion. The line that is not selected is ignored. With `auto_en`=0, both lines are ignored.
- R9: With `auto_en`=1 and `trig_sel`=1, a rising edge of `flag` is the trigger. After one software start, and with `flag` left uncleared, exactly two conversions complete.
- R10: A write (`sel_wr`) goes to a holding register. The active channel and reference copy the holding register whenever no conversion is running, and stay unchanged from the starting tick until the end of the conversion.
- R11: Active channel code 4'b1000 is the temperature sensor. While it is selected, `act_ref` reads 1 (internal reference) whatever reference was written. `act_ref`=0 means the supply reference.
- R12: Dropping `en` aborts any running conversion. `busy` is low on the next clock, and the next conversion after re-enable lasts 25 ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| start_wr | input | 1 | Software start strobe |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 2 | 0 free-run, 1 flag, 2/3 external line 0/1 |
| ext_trig | input | 2 | External trigger lines |
| ps_sel | input | 3 | Prescaler code |
| sel_wr | input | 1 | Write strobe for channel/reference |
| sel_ch | input | 4 | Channel code to write |
| sel_ref | input | 1 | Reference to write (1 internal) |
| cmp | input | 1 | Comparator result |
| flag_clr | input | 1 | Completion flag clear strobe |
| irq_en | input | 1 | Interrupt enable |
| dac_code | output | 10 | Trial code to DAC |
| act_ch | output | 4 | Active channel |
| act_ref | output | 1 | Active reference |
| busy | output | 1 | Start/busy bit |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 10 | Conversion result |
| flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Completion and software flag clearing can land in the same clock. The bench provokes this by watching `res_valid` and raising `flag_clr` within that same cycle. It then requires `flag` to read 1 on the next cycle; a separate pulse with no completion nearby must read 0. A second collision is a selection write made in the middle of a conversion. The active channel is checked to still show the old code until after the result strobe, and the new code afterwards.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CH_W        = 4;
  localparam int TS_W        = 2;
  localparam int TS_FREE     = 0;
  localparam int TS_FLAG     = 1;
  localparam int TS_EXT_BASE = 2;
  localparam logic [CH_W-1:0] TEMP_CH = 4'b1000;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic            ref_int;
  } sel_t;
endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);
  localparam int CNT_W = (1 << PS_W);

  logic [CNT_W-1:0] cnt, ratio;

  always_comb begin
    if (ps_sel == '0) ratio = CNT_W'(2);
    else              ratio = CNT_W'(1) << ps_sel;
  end

  assign tick = en && (cnt >= ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/sar_trigger.sv
module sar_trigger import sar_pkg::*; #(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            auto_en,
  input  logic [TS_W-1:0] trig_sel,
  input  logic [NEXT-1:0] ext_trig,
  input  logic            flag,
  output logic            hit
);
  logic src, src_q;

  always_comb begin
    src = 1'b0;
    if (int'(trig_sel) == TS_FLAG) src = flag;
    for (int i = 0; i < NEXT; i++)
      if (int'(trig_sel) == TS_EXT_BASE + i) src = ext_trig[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign hit = auto_en && (int'(trig_sel) != TS_FREE) && src && !src_q;
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES       = 10,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           go,
  input  logic           restart,
  input  logic           cmp,
  output logic           busy,
  output logic           run,
  output logic           res_valid,
  output logic [RES-1:0] dac,
  output logic [RES-1:0] res_data
);
  localparam int CW = $clog2(FIRST_LEN + 1);

  logic [CW-1:0]  cyc, len, p_present, p_last;
  logic           first;
  logic [RES-1:0] mask, trial;

  assign len       = first ? CW'(FIRST_LEN) : CW'(NORM_LEN);
  assign p_present = len - CW'(RES + 1);
  assign p_last    = len - CW'(1);
  assign trial     = cmp ? dac : (dac & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; run <= 1'b0; cyc <= '0; first <= 1'b1;
      mask <= '0; dac <= '0; res_valid <= 1'b0; res_data <= '0;
    end else if (!en) begin
      busy <= 1'b0; run <= 1'b0; cyc <= '0; first <= 1'b1;
      mask <= '0; dac <= '0; res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (go && !busy) busy <= 1'b1;
      if (tick && busy) begin
        if (!run) begin
          run <= 1'b1; cyc <= CW'(1); dac <= '0; mask <= '0;
        end else begin
          cyc <= cyc + CW'(1);
          if (cyc == p_present) begin
            mask <= {1'b1, {(RES-1){1'b0}}};
            dac  <= {1'b1, {(RES-1){1'b0}}};
          end else if (cyc > p_present) begin
            if (cyc == p_last) begin
              res_data  <= trial;
              dac       <= trial;
              res_valid <= 1'b1;
              mask      <= '0;
              first     <= 1'b0;
              run       <= 1'b0;
              busy      <= restart;
            end else begin
              dac  <= trial | (mask >> 1);
              mask <= mask >> 1;
            end
          end
        end
      end
    end
  end

  AST_RUN_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> busy); // R2
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy)); // R2
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask)); // R5
  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc <= len)); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !run)); // R12
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq import sar_pkg::*; #(
  parameter int RES       = 10,
  parameter int PS_W      = 3,
  parameter int NEXT      = 2,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start_wr,
  input  logic            auto_en,
  input  logic [TS_W-1:0] trig_sel,
  input  logic [NEXT-1:0] ext_trig,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            sel_wr,
  input  logic [CH_W-1:0] sel_ch,
  input  logic            sel_ref,
  input  logic            cmp,
  input  logic            flag_clr,
  input  logic            irq_en,
  output logic [RES-1:0]  dac_code,
  output logic [CH_W-1:0] act_ch,
  output logic            act_ref,
  output logic            busy,
  output logic            res_valid,
  output logic [RES-1:0]  res_data,
  output logic            flag,
  output logic            irq
);
  logic tick, trig_hit, go, restart, run;
  sel_t hold_q, act_q;

  sar_prescale #(.PS_W(PS_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .en(en), .ps_sel(ps_sel), .tick(tick));

  sar_trigger #(.NEXT(NEXT)) u_trigger (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .trig_sel(trig_sel),
    .ext_trig(ext_trig), .flag(flag), .hit(trig_hit));

  assign go      = start_wr || trig_hit;
  assign restart = auto_en && (int'(trig_sel) == TS_FREE);

  sar_engine #(.RES(RES), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .go(go),
    .restart(restart), .cmp(cmp), .busy(busy), .run(run),
    .res_valid(res_valid), .dac(dac_code), .res_data(res_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (sel_wr) hold_q <= '{ch: sel_ch, ref_int: sel_ref};
      if (!run)   act_q  <= hold_q;
    end
  end

  assign act_ch  = act_q.ch;
  assign act_ref = act_q.ref_int || (act_q.ch == TEMP_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (res_valid) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  assign irq = flag && irq_en;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> flag); // R6
  AST_CLR_WINS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !res_valid) |=> !flag); // R6
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(act_q)); // R10
endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, start_wr = 0, auto_en = 0, sel_wr = 0, sel_ref = 0;
  logic flag_clr = 0, irq_en = 0, cmp;
  logic [1:0] trig_sel = 0, ext_trig = 0;
  logic [2:0] ps_sel = 0;
  logic [3:0] sel_ch = 0;
  logic [9:0] dac_code, res_data, vin = 0;
  logic [3:0] act_ch;
  logic act_ref, busy, res_valid, flag, irq;

  int errors = 0, checks = 0, edge_no = 0, en_edge = 0, nrat = 2;
  bit done_run = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;
  always_comb cmp = (vin >= dac_code);

  sar_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_wr(start_wr), .auto_en(auto_en),
    .trig_sel(trig_sel), .ext_trig(ext_trig), .ps_sel(ps_sel), .sel_wr(sel_wr),
    .sel_ch(sel_ch), .sel_ref(sel_ref), .cmp(cmp), .flag_clr(flag_clr),
    .irq_en(irq_en), .dac_code(dac_code), .act_ch(act_ch), .act_ref(act_ref),
    .busy(busy), .res_valid(res_valid), .res_data(res_data), .flag(flag), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enable(input int code);
    @(negedge clk); en = 0; ps_sel = 3'(code);
    nrat = (code == 0) ? 2 : (1 << code);
    @(negedge clk); en = 1; en_edge = edge_no + 1;
  endtask

  task automatic kick(output int s);
    @(negedge clk); start_wr = 1; s = edge_no + 1;
    @(negedge clk); start_wr = 0;
  endtask

  task automatic wait_done(output int e);
    e = -1;
    for (int i = 0; i < 40000; i++) begin
      if (res_valid) begin e = edge_no; break; end
      @(negedge clk);
    end
  endtask

  function automatic int exp_end(input int s, input int len);
    int base, t0;
    base = en_edge - 1;
    t0 = base + ((s - base) / nrat + 1) * nrat;
    return t0 + (len - 1) * nrat;
  endfunction

  task automatic timed_conv(input int len, input string req, input int val);
    int s, e;
    vin = 10'(val);
    kick(s);
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    wait_done(e);
    chk(e == exp_end(s, len), req, e, exp_end(s, len));
    chk(res_data == 10'(val), "R5 result", int'(res_data), val);
    @(negedge clk);
    chk(busy === 1'b0, "R2 busy cleared", int'(busy), 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s, e, e2, cnt;
    repeat (3) @(negedge clk);
    chk(busy == 0 && flag == 0 && res_valid == 0 && irq == 0 && dac_code == 0,
        "reset state", int'(busy), 0);
    rst_n = 1;
    // R2: start ignored while disabled
    kick(s); @(negedge clk);
    chk(busy == 0, "R2 start while disabled", int'(busy), 0);

    // R1 R3 R4: prescaler sweep, first then normal length
    for (int c = 0; c < 8; c++) begin
      enable(c);
      timed_conv(25, "R4 first length", 100 + c);
      timed_conv(13, "R3 normal length / R1 divide", 700 - c);
    end

    // R5: exhaustive input sweep at divide 2
    enable(0);
    timed_conv(25, "R4 first length", 0);
    for (int v = 0; v < 1024; v++) timed_conv(13, "R3 normal length", v);

    // R6: flag, irq, clear, and the completion/clear collision
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    irq_en = 0; timed_conv(13, "R3 normal length", 5);
    chk(flag == 1 && irq == 0, "R6 flag with irq off", int'(irq), 0);
    irq_en = 1; @(negedge clk);
    chk(irq == 1, "R6 irq follows flag", int'(irq), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk(flag == 0 && irq == 0, "R6 clear", int'(flag), 0);
    vin = 10'd9; kick(s); wait_done(e);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(flag == 1, "R6 completion beats clear", int'(flag), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R10 R11: selection buffering and temperature channel
    @(negedge clk); sel_wr = 1; sel_ch = 4'd3; sel_ref = 0;
    @(negedge clk); sel_wr = 0; @(negedge clk);
    chk(act_ch == 3 && act_ref == 0, "R10 idle copy", int'(act_ch), 3);
    vin = 10'd40; kick(s); repeat (6) @(negedge clk);
    sel_wr = 1; sel_ch = 4'd5; @(negedge clk); sel_wr = 0; repeat (3) @(negedge clk);
    chk(act_ch == 3, "R10 frozen during conversion", int'(act_ch), 3);
    wait_done(e); @(negedge clk); @(negedge clk);
    chk(act_ch == 5, "R10 applied after conversion", int'(act_ch), 5);
    sel_wr = 1; sel_ch = 4'b1000; sel_ref = 0; @(negedge clk); sel_wr = 0;
    @(negedge clk);
    chk(act_ch == 8 && act_ref == 1, "R11 temp forces internal ref", int'(act_ref), 1);

    // R7: free-running
    auto_en = 1; trig_sel = 0; vin = 10'd321;
    repeat (10) @(negedge clk);
    chk(busy == 0, "R7 no self start", int'(busy), 0);
    kick(s); wait_done(e); @(negedge clk); wait_done(e2);
    chk(e2 - e == 13 * nrat, "R7 restart spacing", e2 - e, 13 * nrat);
    chk(busy == 1 && res_data == 321, "R7 busy held", int'(busy), 1);
    @(negedge clk); wait_done(e);
    chk(e - e2 == 13 * nrat, "R7 spacing with flag set", e - e2, 13 * nrat);
    enable(0);

    // R8: external trigger select
    trig_sel = 2; auto_en = 1; vin = 10'd77;
    @(negedge clk); ext_trig = 2'b10; repeat (3) @(negedge clk); ext_trig = 0;
    chk(busy == 0, "R8 unselected line ignored", int'(busy), 0);
    ext_trig = 2'b01; @(negedge clk); ext_trig = 0;
    chk(busy == 1, "R8 selected line starts", int'(busy), 1);
    wait_done(e);
    chk(res_data == 77, "R8 result", int'(res_data), 77);
    auto_en = 0; @(negedge clk); ext_trig = 2'b01; repeat (3) @(negedge clk); ext_trig = 0;
    chk(busy == 0, "R8 ignored without auto", int'(busy), 0);

    // R9: flag as trigger, chain stops while flag stays set
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    auto_en = 1; trig_sel = 1; kick(s); cnt = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (res_valid) cnt++; end
    chk(cnt == 2, "R9 two conversions", cnt, 2);
    auto_en = 0; trig_sel = 0;

    // R12: abort and re-arm
    vin = 10'd600; kick(s); repeat (5) @(negedge clk);
    en = 0; @(negedge clk);
    chk(busy == 0, "R12 abort", int'(busy), 0);
    en = 1; en_edge = edge_no + 1;
    timed_conv(25, "R12 re-armed first length", 600);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule